// File: doc/BRIEF.md
# PAM-5 Partial-Response Transmit Shaper

This block shapes the transmit spectrum of one twisted pair in a multi-pair baseband transmitter. On each 125 MHz clock it can take one five-level symbol, given as a 3-bit two's-complement code. It then produces one DAC sample equal to three quarters of the current level plus one quarter of the level accepted before it. This two-tap partial response lowers the energy the line driver puts above roughly 30 MHz. At 125 Mbaud and two information bits per symbol, one pair carries 250 Mb/s.

The sample is a signed count of quarter-levels, computed as 3*x(n) + x(n-1) from shifts and adds alone. A valid strobe qualifies each input symbol. Codes that do not map to a legal level are flagged and treated as zero. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `pam5_pr_shaper`

## Requirements
- R1: Codes 3'b110, 3'b111, 3'b000, 3'b001 and 3'b010 on `sym_code` are decoded as the levels -2, -1, 0, +1 and +2.
- R2: Codes 3'b011, 3'b100 and 3'b101 raise `sym_err` with the sample they produce and are used as level 0, both for the current term and as the stored previous symbol.
- R3: The clock edge that accepts a symbol (`sym_valid` high) updates `dac_sample` to 3*x(n) + x(n-1) in quarter-level units, as a 6-bit two's-complement value, and the result is visible after that edge.
- R4: `dac_valid` is high for exactly the cycle that follows each accepted symbol and low otherwise, and `sym_err` is never high while `dac_valid` is low.
- R5: While `sym_valid` is low, the stored previous symbol and `dac_sample` keep their values. The next accepted symbol is therefore combined with the last one accepted before the gap.
- R6: While reset is active, `dac_sample` is 0 and both flags are low. The previous symbol is cleared, so the first sample after reset is three times the first level.
- R7: `dac_sample` always stays within -8..+8. Any value outside that range would be clamped to the nearer limit.
- R8: Back-to-back symbols are accepted on every clock, with one sample produced per symbol period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Input symbol qualifier and filter enable |
| sym_code | input | 3 | Two's-complement symbol code |
| dac_sample | output | 6 | Shaped sample, signed quarter-levels |
| dac_valid | output | 1 | Sample updated on the previous edge |
| sym_err | output | 1 | The sample came from an illegal code |

## Verification
The assertions check on every cycle that the output stays inside the quarter-level range, that an idle input clears the valid flag and freezes both the delay element and the sample, that the error flag is only ever seen with a valid sample, and that an illegal code decodes to level zero. The numeric result of the two-tap sum, the decode table for each code, the carry of the previous symbol across idle gaps and the first sample after reset depend on data history. Only the bench's scoreboard, with its own model of the filter, can show those.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int CODE_W  = 3;
  localparam int LVL_W   = 3;
  localparam int MAX_LVL = 2;
  localparam int OUT_W   = 6;
  localparam int OUT_MAX = 8;

  typedef struct packed {
    logic signed [LVL_W-1:0] lvl;
    logic                    bad;
  } sym_dec_t;
endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pps_sym_decode.sv
module pps_sym_decode
  import pps_pkg::*;
#(
  parameter int C_W  = CODE_W,
  parameter int L_W  = LVL_W,
  parameter int LMAX = MAX_LVL
) (
  input  logic [C_W-1:0] code,
  output sym_dec_t       dec
);
  logic signed [C_W-1:0] code_s;
  logic                  too_high;
  logic                  too_low;

  always_comb begin
    code_s   = signed'(code);
    too_high = (int'(code_s) >  LMAX);
    too_low  = (int'(code_s) < -LMAX);
    dec.bad  = too_high | too_low;
    dec.lvl  = dec.bad ? '0 : L_W'(code_s);
  end

  always_comb begin
    AST_BAD_IS_ZERO: assert (!dec.bad || dec.lvl == '0); // R2
  end
endmodule

// File: rtl/pps_fir_core.sv
module pps_fir_core
  import pps_pkg::*;
#(
  parameter int L_W  = LVL_W,
  parameter int O_W  = OUT_W,
  parameter int OMAX = OUT_MAX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  sym_dec_t              dec,
  output logic signed [O_W-1:0] sample,
  output logic                  smp_valid,
  output logic                  smp_err
);
  localparam int SUM_W = L_W + 3;

  logic signed [L_W-1:0]   prev_q, prev_d;
  logic signed [O_W-1:0]   smp_q, smp_d;
  logic                    vld_q, vld_d;
  logic                    err_q, err_d;
  logic signed [SUM_W-1:0] cur_ext, prev_ext, sum;
  logic signed [O_W-1:0]   clamped;

  // three-quarter term as (x<<1)+x, plus one-quarter term
  always_comb begin
    cur_ext  = SUM_W'(dec.lvl);
    prev_ext = SUM_W'(prev_q);
    sum      = (cur_ext <<< 1) + cur_ext + prev_ext;
    if (int'(sum) > OMAX)       clamped = O_W'(OMAX);
    else if (int'(sum) < -OMAX) clamped = -O_W'(OMAX);
    else                        clamped = O_W'(sum);
  end

  always_comb begin
    prev_d = prev_q;
    smp_d  = smp_q;
    vld_d  = 1'b0;
    err_d  = 1'b0;
    if (en) begin
      prev_d = dec.lvl;
      smp_d  = clamped;
      vld_d  = 1'b1;
      err_d  = dec.bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      smp_q  <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      smp_q  <= smp_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign sample    = smp_q;
  assign smp_valid = vld_q;
  assign smp_err   = err_q;

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(smp_q) <= OMAX) && (int'(smp_q) >= -OMAX)); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld_q); // R4
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> vld_q); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(prev_q) && $stable(smp_q))); // R5
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> vld_q); // R4
endmodule

// File: rtl/pam5_pr_shaper.sv
module pam5_pr_shaper
  import pps_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_valid,
  input  logic [CODE_W-1:0]       sym_code,
  output logic signed [OUT_W-1:0] dac_sample,
  output logic                    dac_valid,
  output logic                    sym_err
);
  logic     core_rst_n;
  sym_dec_t dec;

  pps_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  pps_sym_decode #(.C_W(CODE_W), .L_W(LVL_W), .LMAX(MAX_LVL)) u_dec (
    .code (sym_code),
    .dec  (dec)
  );

  pps_fir_core #(.L_W(LVL_W), .O_W(OUT_W), .OMAX(OUT_MAX)) u_core (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .en        (sym_valid),
    .dec       (dec),
    .sample    (dac_sample),
    .smp_valid (dac_valid),
    .smp_err   (sym_err)
  );
endmodule

// File: tb/pam5_pr_shaper_bench.sv
module pam5_pr_shaper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic [2:0] sym_code = 3'b000;
  logic signed [5:0] dac_sample;
  logic       dac_valid;
  logic       sym_err;

  typedef struct {
    bit    vld;
    int    smp;
    bit    err;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   m_prev = 0;
  int   m_last = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  pam5_pr_shaper u_pam5_pr_shaper (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
    .dac_sample(dac_sample), .dac_valid(dac_valid), .sym_err(sym_err)
  );

  // model of the code table (R1) and illegal codes (R2)
  function automatic int lvl_of(input logic [2:0] c, output bit bad);
    bad = 1'b0;
    case (c)
      3'b110: return -2;
      3'b111: return -1;
      3'b000: return 0;
      3'b001: return 1;
      3'b010: return 2;
      default: begin bad = 1'b1; return 0; end
    endcase
  endfunction

  task automatic drive(input bit v, input logic [2:0] c, input string req);
    exp_t e;
    bit   bad;
    int   l;
    @(negedge clk);
    sym_valid = v;
    sym_code  = c;
    if (v) begin
      l = lvl_of(c, bad);
      m_last = 3 * l + m_prev;   // R3
      m_prev = l;
      e.vld = 1'b1; e.smp = m_last; e.err = bad;
    end else begin
      e.vld = 1'b0; e.smp = m_last; e.err = 1'b0; // R5 hold
    end
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: compares each result after the edge that made it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(dac_valid == e.vld, {e.req, " valid"}, int'(dac_valid), int'(e.vld));
        check(int'(dac_sample) == e.smp, {e.req, " sample"}, int'(dac_sample), e.smp);
        check(sym_err == e.err, {e.req, " err"}, int'(sym_err), int'(e.err));
        check(int'(dac_sample) <= 8 && int'(dac_sample) >= -8, "R7 range",
              int'(dac_sample), 8);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check(dac_valid == 1'b0, "R6 reset valid", int'(dac_valid), 0);
    check(dac_sample == '0, "R6 reset sample", int'(dac_sample), 0);
    check(sym_err == 1'b0, "R6 reset err", int'(sym_err), 0);
    rst_n = 1'b1;
    repeat (3) drive(1'b0, 3'b000, "R6 idle");
    // R6: first sample is 3*x with cleared history
    drive(1'b1, 3'b010, "R6 first");
    // R1 and R8: every legal code back to back
    drive(1'b1, 3'b110, "R1");
    drive(1'b1, 3'b111, "R1");
    drive(1'b1, 3'b000, "R1");
    drive(1'b1, 3'b001, "R1");
    drive(1'b1, 3'b010, "R8");
    drive(1'b1, 3'b010, "R7 max");
    drive(1'b1, 3'b110, "R3");
    drive(1'b1, 3'b110, "R7 min");
    // R5: gap then resume with pre-gap history
    drive(1'b1, 3'b001, "R5");
    drive(1'b0, 3'b010, "R5 idle");
    drive(1'b0, 3'b110, "R5 idle");
    drive(1'b1, 3'b111, "R5 resume");
    // R2: illegal codes act as zero, also as history
    drive(1'b1, 3'b010, "R3");
    drive(1'b1, 3'b011, "R2");
    drive(1'b1, 3'b001, "R2 next");
    drive(1'b1, 3'b100, "R2");
    drive(1'b1, 3'b101, "R2");
    drive(1'b0, 3'b100, "R4 idle err");
    drive(1'b1, 3'b111, "R2 after");
    // R3/R8: alternating pattern
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, (i % 2 == 0) ? 3'b010 : 3'b110, "R8 alt");
      if (i % 5 == 4) drive(1'b0, 3'b001, "R4 gap");
    end
    drive(1'b0, 3'b000, "R4 tail");
    drive(1'b0, 3'b000, "R4 tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule